// File: doc/BRIEF.md
# Tagged-Byte Control Register Interface

This block is the control port of an audio processor. It is a write-only target on a two-wire serial bus (SCL clock, SDA data). It watches for START and STOP conditions and compares the first byte of each transfer with its own device address. Once addressed, it acknowledges every byte that follows. The top bit of each later byte says what the byte is. A clear top bit makes the byte a function selector. A set top bit makes it a value to store. Selectors and values may be mixed freely within one transfer.

The values land in a bank of nine function registers, and the whole bank is presented as one flat parallel output. The functions are numbered as follows: 0 volume/loudness, 1 surround/output/effect, 2 bass, 3 treble, 4 right speaker, 5 left speaker, 6 right aux, 7 left aux, 8 input stage. A selector can also switch on a stepping mode. In that mode each value goes to the next function index, and the index wraps around after the last function. Every write pulses a one-cycle strobe that carries the index written.

SCL and SDA are brought into the system clock through two-flop synchronisers and sampled there. SDA is driven open-drain: the output enable pulls the line low.

Top module: `tbc_ctrl_if`

## Requirements
- R1: The target acknowledges an address byte only when it equals binary 1000_00A0, where A is `addr_sel_i`. This gives 80h or 82h. Any other byte is not acknowledged, including one with bit 0 set (a read request).
- R2: After a matching address, the target pulls SDA low (`sda_oe_o`=1) through the ninth clock of that address byte and of every later byte in the transfer. It releases SDA once that clock ends.
- R3: After a mismatching address, SDA is never driven and all bytes are ignored until the next START. A repeated START is handled exactly like a new START.
- R4: After the address, a byte with bit 7 = 0 is a selector, and its bits 4:1 give the function index. A byte with bit 7 = 1 is a value. Selectors and values may be mixed in any order within one transfer.
- R5: When a selector has bit 0 = 0, every following value is stored, bits 6:0 only, into the selected function.
- R6: When a selector has bit 0 = 1, the first value goes to the selected index plus one, the next to plus two, and so on.
- R7: In stepping mode the index wraps from function 8 back to function 0.
- R8: Reset loads these 7-bit codes: volume 3Fh (maximum attenuation, loudness bit 6 clear); surround/output/effect 1Fh (surround off in bits 6:5 = 0, fixed output bit 4 = 1, maximum effect attenuation in bits 3:0 = Fh); bass 00h and treble 00h (the -14 dB code); the four speaker and aux attenuators 7Fh (mute); input stage 00h.
- R9: A value received after a START but before any selector is acknowledged and then discarded.
- R10: Each stored value raises `wr_stb_o` for exactly one cycle, with `wr_idx_o` giving the function written. The register outputs change only in a strobe cycle.
- R11: A selector whose index is 9 or more is acknowledged. The values that follow it are acknowledged and then discarded, until a valid selector arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_sel_i | input | 1 | Selects address bit 1 (80h or 82h) |
| scl_i | input | 1 | Serial clock line, asynchronous |
| sda_i | input | 1 | Serial data line as seen on the wire, asynchronous |
| sda_oe_o | output | 1 | Pulls SDA low when 1 (open-drain) |
| regs_o | output | NUM_FUNCS*7 | Function registers; function k sits in bits 7k+6:7k |
| wr_stb_o | output | 1 | One-cycle pulse per stored value |
| wr_idx_o | output | clog2(NUM_FUNCS) | Function index of the current write |

## Verification
The assertions rely on two assumptions about the bus. First, SDA moves only while SCL is low, except at START and STOP. Second, each SCL phase lasts many system clocks, so that each edge seen after synchronisation is a clean single event and two stored bytes are never closer than one cycle apart. The bench honours both. It holds each SCL phase for ten clocks, and it changes SDA only after SCL has been low for two clocks. It models the wired-AND of the line as the master's drive ANDed with the inverse of the target's output enable.

// File: rtl/tbc_pkg.sv
package tbc_pkg;
  localparam int BYTE_W = 8;
  localparam int VAL_W  = BYTE_W - 1;
  localparam int SEL_W  = 4;

  // Expected address byte for a given address-select pin value.
  function automatic logic [BYTE_W-1:0] own_addr(input logic a);
    return {6'b100000, a, 1'b0};
  endfunction

  // Next function index in stepping mode, wrapping after the last one.
  function automatic logic [SEL_W-1:0] step_idx(input logic [SEL_W-1:0] idx, input int n);
    return (idx == SEL_W'(n - 1)) ? '0 : idx + 1'b1;
  endfunction

  // Power-on code for each function register.
  function automatic logic [VAL_W-1:0] reset_code(input int idx);
    case (idx)
      0:       return 7'h3F;
      1:       return 7'h1F;
      4, 5, 6, 7: return 7'h7F;
      default: return 7'h00;
    endcase
  endfunction
endpackage

// File: rtl/tbc_sync.sv
module tbc_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '1;
      q_o    <= '1;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/tbc_bus_rx.sv
module tbc_bus_rx
  import tbc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              addr_sel,
  output logic              start_ev,
  output logic              stop_ev,
  output logic              scl_fall_ev,
  output logic              byte_vld,
  output logic [BYTE_W-1:0] byte_data,
  output logic              sda_oe,
  output logic              active
);
  localparam int CNT_W = $clog2(BYTE_W + 1);

  logic              scl_q, sda_q;
  logic              in_addr, ack_ph;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic              scl_rise_ev, byte_full;

  assign scl_rise_ev = scl_s & ~scl_q;
  assign scl_fall_ev = ~scl_s & scl_q;
  assign start_ev    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev     = scl_s & scl_q & ~sda_q & sda_s;
  assign byte_full   = (bit_cnt == CNT_W'(BYTE_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q     <= 1'b1;
      sda_q     <= 1'b1;
      active    <= 1'b0;
      in_addr   <= 1'b0;
      ack_ph    <= 1'b0;
      bit_cnt   <= '0;
      shreg     <= '0;
      sda_oe    <= 1'b0;
      byte_vld  <= 1'b0;
      byte_data <= '0;
    end else begin
      scl_q    <= scl_s;
      sda_q    <= sda_s;
      byte_vld <= 1'b0;
      if (start_ev) begin
        active  <= 1'b1;
        in_addr <= 1'b1;
        ack_ph  <= 1'b0;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
      end else if (stop_ev) begin
        active <= 1'b0;
        ack_ph <= 1'b0;
        sda_oe <= 1'b0;
      end else if (active) begin
        if (scl_rise_ev && !ack_ph && !byte_full) begin
          shreg   <= {shreg[BYTE_W-2:0], sda_s};
          bit_cnt <= bit_cnt + 1'b1;
        end else if (scl_fall_ev) begin
          if (ack_ph) begin
            ack_ph  <= 1'b0;
            sda_oe  <= 1'b0;
            bit_cnt <= '0;
          end else if (byte_full) begin
            if (in_addr) begin
              in_addr <= 1'b0;
              if (shreg == own_addr(addr_sel)) begin
                ack_ph <= 1'b1;
                sda_oe <= 1'b1;
              end else begin
                active <= 1'b0;
              end
            end else begin
              ack_ph    <= 1'b1;
              sda_oe    <= 1'b1;
              byte_vld  <= 1'b1;
              byte_data <= shreg;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/tbc_regbank.sv
module tbc_regbank
  import tbc_pkg::*;
#(
  parameter int NUM_FUNCS = 9,
  parameter int IDX_W     = $clog2(NUM_FUNCS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_ev,
  input  logic                       byte_vld,
  input  logic [BYTE_W-1:0]          byte_data,
  output logic [NUM_FUNCS*VAL_W-1:0] regs_o,
  output logic                       wr_stb_o,
  output logic [IDX_W-1:0]           wr_idx_o
);
  logic [VAL_W-1:0] regs_q [NUM_FUNCS];
  logic [SEL_W-1:0] cur_idx, sel_field, tgt_idx;
  logic             sel_ok, inc_mode;

  assign sel_field = byte_data[SEL_W:1];
  assign tgt_idx   = inc_mode ? step_idx(cur_idx, NUM_FUNCS) : cur_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_FUNCS; i++) regs_q[i] <= reset_code(i);
      cur_idx  <= '0;
      sel_ok   <= 1'b0;
      inc_mode <= 1'b0;
      wr_stb_o <= 1'b0;
      wr_idx_o <= '0;
    end else begin
      wr_stb_o <= 1'b0;
      if (start_ev) begin
        sel_ok <= 1'b0;
      end else if (byte_vld) begin
        if (!byte_data[BYTE_W-1]) begin
          cur_idx  <= sel_field;
          inc_mode <= byte_data[0];
          sel_ok   <= ({1'b0, sel_field} < (SEL_W+1)'(NUM_FUNCS));
        end else if (sel_ok) begin
          regs_q[tgt_idx[IDX_W-1:0]] <= byte_data[VAL_W-1:0];
          cur_idx  <= tgt_idx;
          wr_stb_o <= 1'b1;
          wr_idx_o <= tgt_idx[IDX_W-1:0];
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_FUNCS; g++) begin : g_flat
    assign regs_o[g*VAL_W +: VAL_W] = regs_q[g];
  end
endmodule

// File: rtl/tbc_ctrl_if.sv
module tbc_ctrl_if #(
  parameter int NUM_FUNCS = 9
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            addr_sel_i,
  input  logic                            scl_i,
  input  logic                            sda_i,
  output logic                            sda_oe_o,
  output logic [NUM_FUNCS*7-1:0]          regs_o,
  output logic                            wr_stb_o,
  output logic [$clog2(NUM_FUNCS)-1:0]    wr_idx_o
);
  import tbc_pkg::*;

  logic [1:0]        sync_w;
  logic              start_w, stop_w, scl_fall_w, byte_vld_w, active_w;
  logic [BYTE_W-1:0] byte_w;

  tbc_sync #(.W(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({scl_i, sda_i}),
    .q_o   (sync_w)
  );

  tbc_bus_rx u_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_s       (sync_w[1]),
    .sda_s       (sync_w[0]),
    .addr_sel    (addr_sel_i),
    .start_ev    (start_w),
    .stop_ev     (stop_w),
    .scl_fall_ev (scl_fall_w),
    .byte_vld    (byte_vld_w),
    .byte_data   (byte_w),
    .sda_oe      (sda_oe_o),
    .active      (active_w)
  );

  tbc_regbank #(.NUM_FUNCS(NUM_FUNCS)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_ev  (start_w),
    .byte_vld  (byte_vld_w),
    .byte_data (byte_w),
    .regs_o    (regs_o),
    .wr_stb_o  (wr_stb_o),
    .wr_idx_o  (wr_idx_o)
  );
endmodule

// File: rtl/tbc_ctrl_chk.sv
module tbc_ctrl_chk #(
  parameter int NUM_FUNCS = 9,
  parameter int IDX_W     = $clog2(NUM_FUNCS)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   scl_fall,
  input logic                   start_ev,
  input logic                   stop_ev,
  input logic                   active,
  input logic                   sda_oe,
  input logic                   wr_stb,
  input logic [IDX_W-1:0]       wr_idx,
  input logic [NUM_FUNCS*7-1:0] regs
);
  // R2: the SDA drive changes only on an SCL fall or a START/STOP
  a_r2_oe_edges: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> $past(scl_fall | start_ev | stop_ev));

  // R3: SDA is never driven outside an addressed transfer
  a_r3_oe_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> active);

  // R10: the register bank changes only with a strobe
  a_r10_regs_with_stb: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regs) |-> wr_stb);

  // R10: the strobe lasts one cycle
  a_r10_stb_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  // R11: writes only ever reach an existing function
  a_r11_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (32'(wr_idx) < NUM_FUNCS));
endmodule

bind tbc_ctrl_if tbc_ctrl_chk #(.NUM_FUNCS(NUM_FUNCS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_fall (scl_fall_w),
  .start_ev (start_w),
  .stop_ev  (stop_w),
  .active   (active_w),
  .sda_oe   (sda_oe_o),
  .wr_stb   (wr_stb_o),
  .wr_idx   (wr_idx_o),
  .regs     (regs_o)
);

// File: tb/tb_tbc_ctrl_if.sv
`timescale 1ns/1ps
module tb_tbc_ctrl_if;
  localparam int NF   = 9;
  localparam int HOLD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addr_sel = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe;
  logic [NF*7-1:0] regs;
  logic wr_stb;
  logic [3:0] wr_idx;
  wire  sda_line = m_sda & ~sda_oe;

  always #2.5 clk = ~clk;

  tbc_ctrl_if #(.NUM_FUNCS(NF)) dut (
    .clk(clk), .rst_n(rst_n), .addr_sel_i(addr_sel), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .regs_o(regs), .wr_stb_o(wr_stb), .wr_idx_o(wr_idx)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model
  logic [6:0] exp_r [NF];
  int  exp_stb = 0;
  int  m_idx = 0;
  bit  m_ok = 0, m_inc = 0;

  // strobe monitor
  int stb_cnt = 0, run = 0, max_run = 0;
  always @(negedge clk) begin
    if (rst_n && wr_stb) begin
      stb_cnt++;
      run++;
      if (run > max_run) max_run = run;
    end else run = 0;
  end

  task automatic check(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, expv);
    end
  endtask

  function automatic logic [6:0] pwr_code(input int k);
    if (k >= 4 && k <= 7) return 7'h7F;
    if (k == 0) return 7'h3F;
    if (k == 1) return 7'h1F;
    return 7'h00;
  endfunction

  function automatic void model_start();
    m_ok = 0;
  endfunction

  function automatic void model_byte(input logic [7:0] b);
    if (b[7] == 1'b0) begin
      m_idx = int'(b[4:1]);
      m_ok  = (m_idx < NF);
      m_inc = b[0];
    end else if (m_ok) begin
      if (m_inc) m_idx = (m_idx + 1) % NF;
      exp_r[m_idx] = b[6:0];
      exp_stb++;
    end
  endfunction

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; hold(HOLD);
    m_scl = 1'b1; hold(HOLD);
    m_sda = 1'b0; hold(HOLD);
    m_scl = 1'b0; hold(2);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; hold(HOLD);
    m_scl = 1'b1; hold(HOLD);
    m_sda = 1'b1; hold(HOLD);
  endtask

  task automatic bus_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; hold(HOLD);
      m_scl = 1'b1; hold(HOLD);
      m_scl = 1'b0; hold(2);
    end
    m_sda = 1'b1; hold(HOLD);
    m_scl = 1'b1; hold(HOLD/2);
    acked = (sda_line == 1'b0);
    hold(HOLD/2);
    m_scl = 1'b0; hold(2);
  endtask

  // Sends address and n bytes; returns acknowledge mask (bit0 = address).
  task automatic frame(input logic [7:0] ad, input logic [7:0] b [8], input int n,
                       input bit model_it, output int mask);
    bit a;
    mask = 0;
    bus_start();
    if (model_it) model_start();
    bus_byte(ad, a);
    if (a) mask |= 1;
    for (int k = 0; k < n; k++) begin
      bus_byte(b[k], a);
      if (a) mask |= (1 << (k + 1));
      if (model_it) model_byte(b[k]);
    end
    bus_stop();
    hold(8);
  endtask

  task automatic check_bank(input string req);
    for (int k = 0; k < NF; k++)
      check(req, int'(regs[k*7 +: 7]), int'(exp_r[k]));
    check(req, stb_cnt, exp_stb);
    check("R2 released", int'(sda_oe), 0);
  endtask

  task automatic t_reset();
    for (int k = 0; k < NF; k++) exp_r[k] = pwr_code(k);
    check_bank("R8 reset codes");
  endtask

  task automatic t_fixed();
    int mk;
    frame(8'h80, '{8'h04, 8'h85, 8'h9A, 0, 0, 0, 0, 0}, 3, 1, mk);
    check("R2 ack every byte", mk, 'hF);
    check("R5 fixed target bass", int'(regs[2*7 +: 7]), 'h1A);
    check_bank("R5 fixed mode");
  endtask

  task automatic t_incr();
    int mk;
    frame(8'h80, '{8'h07, 8'h81, 8'h82, 8'h83, 0, 0, 0, 0}, 4, 1, mk);
    check("R6 ack", mk, 'h1F);
    check("R6 first to idx+1", int'(regs[4*7 +: 7]), 'h01);
    check_bank("R6 stepping");
  endtask

  task automatic t_wrap();
    int mk;
    frame(8'h80, '{8'h0F, 8'hC1, 8'hC2, 8'hC3, 0, 0, 0, 0}, 4, 1, mk);
    check("R7 ack", mk, 'h1F);
    check("R7 wrap to 0", int'(regs[0 +: 7]), 'h42);
    check_bank("R7 wrap");
  endtask

  task automatic t_mixed();
    int mk;
    frame(8'h80, '{8'h10, 8'hAA, 8'h00, 8'h99, 8'h98, 8'h0C, 8'hB3, 0}, 7, 1, mk);
    check("R4 ack", mk, 'hFF);
    check_bank("R4 mixed selectors");
  endtask

  task automatic t_nosel();
    int mk;
    frame(8'h80, '{8'hF0, 8'hF1, 8'h04, 8'h80, 0, 0, 0, 0}, 4, 1, mk);
    check("R9 ack discarded values", mk, 'h1F);
    check_bank("R9 value before selector");
  endtask

  task automatic t_mismatch();
    int mk;
    frame(8'h82, '{8'h04, 8'hFF, 0, 0, 0, 0, 0, 0}, 2, 0, mk);
    check("R1 82h refused when pin low", mk, 0);
    check_bank("R3 ignored after mismatch");
    frame(8'h81, '{8'h04, 8'hFF, 0, 0, 0, 0, 0, 0}, 2, 0, mk);
    check("R1 read request refused", mk, 0);
    check_bank("R3 read ignored");
  endtask

  task automatic t_rstart();
    bit a;
    bus_start(); model_start();
    bus_byte(8'h80, a); check("R3 addr ack", int'(a), 1);
    bus_byte(8'h0A, a); model_byte(8'h0A);
    bus_byte(8'h91, a); model_byte(8'h91);
    bus_start();
    bus_byte(8'h84, a); check("R3 rstart mismatch", int'(a), 0);
    bus_byte(8'h92, a); check("R3 ignored byte", int'(a), 0);
    bus_start(); model_start();
    bus_byte(8'h80, a); check("R3 rstart match", int'(a), 1);
    bus_byte(8'h93, a); check("R9 ack after rstart", int'(a), 1);
    bus_stop(); hold(8);
    check("R3 left speaker kept", int'(regs[5*7 +: 7]), 'h11);
    check_bank("R3 repeated start");
  endtask

  task automatic t_addrsel();
    int mk;
    addr_sel = 1'b1;
    hold(4);
    frame(8'h82, '{8'h02, 8'h8C, 0, 0, 0, 0, 0, 0}, 2, 1, mk);
    check("R1 82h accepted", mk, 'h7);
    frame(8'h80, '{8'h02, 8'h8D, 0, 0, 0, 0, 0, 0}, 2, 0, mk);
    check("R1 80h refused when pin high", mk, 0);
    check_bank("R1 address select");
    addr_sel = 1'b0;
    hold(4);
  endtask

  task automatic t_range();
    int mk;
    frame(8'h80, '{8'h18, 8'h85, 8'h86, 8'h10, 8'h87, 0, 0, 0}, 5, 1, mk);
    check("R11 ack", mk, 'h3F);
    check("R11 input stage", int'(regs[8*7 +: 7]), 'h07);
    check_bank("R11 out-of-range selector");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    hold(5);
    rst_n = 1'b1;
    hold(5);
    t_reset();
    t_fixed();
    t_incr();
    t_wrap();
    t_mixed();
    t_nosel();
    t_mismatch();
    t_rstart();
    t_addrsel();
    t_range();
    check("R10 strobe width", max_run, 1);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule